// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and calendar date in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a century count. A parameterised prescaler divides the system clock down to one advance per second. The running count lives in an internal counter set. A second, host-visible copy follows that set and is the only view the host has.

The host reaches the block through a 16-entry byte register file selected by a four-bit address. Two control bits at address 0x8 govern the transfer between the sets. The read-hold bit freezes the visible copy so a multi-byte read is coherent while the internal count keeps running. The write-hold bit opens the visible copy to host writes, and clearing it loads those values into the internal counters. An oscillator-stop bit halts timekeeping. A spare frequency-test bit is stored for the host.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the clock reads 00:00:00, day 01, date 01, month 01, year 00, century 20, with write-hold, read-hold, oscillator-stop and frequency-test bits all 0.
- R2: Seconds and minutes count 00..59 in BCD and hours 00..23; each wrap carries into the next field, and an hour wrap advances both the date and the day of week, which goes from 07 back to 01.
- R3: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 in February of a non-leap year.
- R4: In a year whose BCD value is a multiple of four (00 included), February runs to day 29.
- R5: After 31 December, month and date become 01, the year advances, and year 99 wraps to 00 while incrementing the century, which wraps from CENT_LAST (default 39) to 00.
- R6: Read data appears on host_rdata one cycle after the address. The layout is 0x8 = {write-hold, read-hold, century[5:0]}, 0x9 = {osc-stop, seconds[6:0]}, 0xA minutes, 0xB hours, 0xC = {0, freq-test, 000, day[2:0]}, 0xD date, 0xE month, 0xF year. Addresses 0x0..0x7 read 0x00 and ignore writes.
- R7: While read-hold is 1 and write-hold is 0, the visible time stays at the count present when read-hold was set, and the internal count keeps advancing. Within a few cycles of read-hold being cleared, the visible time shows the advanced count.
- R8: While write-hold is 1, the visible time is neither updated nor advanced, and it takes host writes to 0x8..0xF. A write to 0x8 with bit 7 = 0 loads the internal counters from the visible values, taking the century from that write's bits [5:0]. The first advance after that load comes TICK_DIV cycles later.
- R9: Host writes to the time fields at 0x9..0xF while write-hold is 0 leave the time unchanged.
- R10: Writing 1 to bit 7 of 0x9 stops counting at any time and reads back as 1; writing 0 resumes counting from the same count.
- R11: Bit 6 of 0xC is host readable and writable at any time, without touching the day field.
- R12: While running and not in write-hold, the count advances by exactly one second every TICK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_addr | input | 4 | Register index |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The bench builds the block with TICK_DIV = 16, so that one second lasts sixteen clock cycles. At that rate every year-end, century-end, leap-February and short-month rollover can be loaded, and it takes effect within a few dozen cycles of the load. Because a second is this short, hold and stop intervals of several seconds fit easily in the run. The default CENT_LAST of 39 is kept, so the bench can load the last century value and check its wrap directly.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{cen: 8'h20, yr: 8'h00, mon: 8'h01, date: 8'h01,
                                 day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // multiple of four in two BCD digits: even tens -> 0,4,8 ; odd tens -> 2,6
  function automatic logic is_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int TICK_DIV = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  cal_t load_val,
  output cal_t now
);
  cal_t nxt;

  always_comb begin
    nxt = now;
    if (now.sec != 8'h59) nxt.sec = bcd_inc(now.sec);
    else begin
      nxt.sec = 8'h00;
      if (now.min != 8'h59) nxt.min = bcd_inc(now.min);
      else begin
        nxt.min = 8'h00;
        if (now.hr != 8'h23) nxt.hr = bcd_inc(now.hr);
        else begin
          nxt.hr  = 8'h00;
          nxt.day = (now.day == 8'h07) ? 8'h01 : now.day + 8'd1;
          if (now.date != last_date(now.mon, now.yr)) nxt.date = bcd_inc(now.date);
          else begin
            nxt.date = 8'h01;
            if (now.mon != 8'h12) nxt.mon = bcd_inc(now.mon);
            else begin
              nxt.mon = 8'h01;
              if (now.yr != 8'h99) nxt.yr = bcd_inc(now.yr);
              else begin
                nxt.yr  = 8'h00;
                nxt.cen = (now.cen == CENT_LAST) ? 8'h00 : bcd_inc(now.cen);
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       now <= CAL_RESET;
    else if (load) now <= load_val;
    else if (tick) now <= nxt;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int         TICK_DIV  = 1000000,
  parameter logic [7:0] CENT_LAST = 8'h39
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_wr,
  input  logic [3:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam logic [3:0] A_CTL  = 4'h8;
  localparam logic [3:0] A_SEC  = 4'h9;
  localparam logic [3:0] A_MIN  = 4'hA;
  localparam logic [3:0] A_HR   = 4'hB;
  localparam logic [3:0] A_DAY  = 4'hC;
  localparam logic [3:0] A_DATE = 4'hD;
  localparam logic [3:0] A_MON  = 4'hE;
  localparam logic [3:0] A_YR   = 4'hF;

  logic w_hold, r_hold, osc_stop, ft_bit;
  logic tick, load;
  cal_t host_set, load_val, now;

  assign load = host_wr && (host_addr == A_CTL) && w_hold && !host_wdata[7];

  always_comb begin
    load_val     = host_set;
    load_val.cen = {2'b00, host_wdata[5:0]};
  end

  rtc_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
    .clk(clk), .rst(rst), .run(!osc_stop && !w_hold), .restart(load), .tick(tick)
  );

  rtc_time_counter #(.CENT_LAST(CENT_LAST)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .load_val(load_val), .now(now)
  );

  // control bits: always writable
  always_ff @(posedge clk) begin
    if (rst) begin
      w_hold   <= 1'b0;
      r_hold   <= 1'b0;
      osc_stop <= 1'b0;
      ft_bit   <= 1'b0;
    end else if (host_wr) begin
      if (host_addr == A_CTL) begin
        w_hold <= host_wdata[7];
        r_hold <= host_wdata[6];
      end
      if (host_addr == A_SEC) osc_stop <= host_wdata[7];
      if (host_addr == A_DAY) ft_bit   <= host_wdata[6];
    end
  end

  // host-visible copy
  always_ff @(posedge clk) begin
    if (rst) host_set <= CAL_RESET;
    else if (!w_hold && !r_hold) host_set <= now;
    else if (w_hold && host_wr) begin
      case (host_addr)
        A_CTL:  host_set.cen  <= {2'b00, host_wdata[5:0]};
        A_SEC:  host_set.sec  <= {1'b0, host_wdata[6:0]};
        A_MIN:  host_set.min  <= {1'b0, host_wdata[6:0]};
        A_HR:   host_set.hr   <= {2'b00, host_wdata[5:0]};
        A_DAY:  host_set.day  <= {5'b00000, host_wdata[2:0]};
        A_DATE: host_set.date <= {2'b00, host_wdata[5:0]};
        A_MON:  host_set.mon  <= {3'b000, host_wdata[4:0]};
        A_YR:   host_set.yr   <= host_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= 8'h00;
    else begin
      case (host_addr)
        A_CTL:  host_rdata <= {w_hold, r_hold, host_set.cen[5:0]};
        A_SEC:  host_rdata <= {osc_stop, host_set.sec[6:0]};
        A_MIN:  host_rdata <= {1'b0, host_set.min[6:0]};
        A_HR:   host_rdata <= {2'b00, host_set.hr[5:0]};
        A_DAY:  host_rdata <= {1'b0, ft_bit, 3'b000, host_set.day[2:0]};
        A_DATE: host_rdata <= {2'b00, host_set.date[5:0]};
        A_MON:  host_rdata <= {3'b000, host_set.mon[4:0]};
        A_YR:   host_rdata <= host_set.yr;
        default: host_rdata <= 8'h00;
      endcase
    end
  end
endmodule

module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic [3:0] host_addr,
  input logic [7:0] host_rdata,
  input logic       w_hold,
  input logic       r_hold,
  input logic       osc_stop,
  input logic       tick,
  input logic       load,
  input logic [7:0] h_sec,
  input logic [7:0] i_sec
);
  // R6
  low_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !host_addr[3] |=> host_rdata == 8'h00);

  // R7
  read_hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (r_hold && !w_hold) |=> $stable(h_sec));

  // R8
  write_hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (w_hold && !host_wr) |=> $stable(h_sec));

  // R8
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> i_sec == $past(h_sec));

  // R10
  osc_stop_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> !tick);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && i_sec == 8'h59) |=> i_sec == 8'h00);
endmodule

bind rtc_calendar_core rtc_calendar_core_chk chk_i (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
  .host_rdata(host_rdata), .w_hold(w_hold), .r_hold(r_hold),
  .osc_stop(osc_stop), .tick(tick), .load(load),
  .h_sec(host_set.sec), .i_sec(now.sec)
);

// File: tb/rtc_calendar_core_tb.sv
module rtc_calendar_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr  = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wd   = 8'h00;
  logic [7:0] rd;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    int s, m, h, dw, d, mo, y, c;
  } tm_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.TICK_DIV(TDIV), .CENT_LAST(8'h39)) dut_i (
    .clk(clk), .rst(rst), .host_wr(wr), .host_addr(addr),
    .host_wdata(wd), .host_rdata(rd)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t adv(input tm_t t);
    tm_t r = t;
    r.s = t.s + 1;
    if (r.s == 60) begin r.s = 0; r.m++; end
    if (r.m == 60) begin r.m = 0; r.h++; end
    if (r.h == 24) begin
      r.h = 0;
      r.dw = (t.dw % 7) + 1;
      r.d++;
      if (r.d > mdays(t.mo, t.y)) begin r.d = 1; r.mo++; end
      if (r.mo == 13) begin r.mo = 1; r.y++; end
      if (r.y == 100) begin r.y = 0; r.c = (t.c + 1) % 40; end
    end
    return r;
  endfunction

  function automatic tm_t mk(int s, int m, int h, int dw, int d, int mo, int y, int c);
    tm_t t;
    t.s = s; t.m = m; t.h = h; t.dw = dw; t.d = d; t.mo = mo; t.y = y; t.c = c;
    return t;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wd = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    addr = a; wr = 1'b0;
    @(negedge clk);
    v = rd;
  endtask

  task automatic load_time(input tm_t t);
    wr_reg(4'h8, 8'h80 | bcd(t.c));
    wr_reg(4'h9, bcd(t.s));
    wr_reg(4'hA, bcd(t.m));
    wr_reg(4'hB, bcd(t.h));
    wr_reg(4'hC, bcd(t.dw));
    wr_reg(4'hD, bcd(t.d));
    wr_reg(4'hE, bcd(t.mo));
    wr_reg(4'hF, bcd(t.y));
    wr_reg(4'h8, bcd(t.c));
  endtask

  // wait k seconds after a load, freeze with read-hold, read all, release
  task automatic sample_after(input tm_t t0, input int k, input string req);
    logic [7:0] v8, v9, va, vb, vc, vd, ve, vf;
    tm_t e = t0;
    for (int i = 0; i < k; i++) e = adv(e);
    repeat (TDIV * k + 5) @(negedge clk);
    wr_reg(4'h8, 8'h40);
    rd_reg(4'h8, v8); rd_reg(4'h9, v9); rd_reg(4'hA, va); rd_reg(4'hB, vb);
    rd_reg(4'hC, vc); rd_reg(4'hD, vd); rd_reg(4'hE, ve); rd_reg(4'hF, vf);
    wr_reg(4'h8, 8'h00);
    check({v8, v9, va, vb, vc, vd, ve, vf} ==
          {8'h40 | bcd(e.c), bcd(e.s), bcd(e.m), bcd(e.h), bcd(e.dw), bcd(e.d), bcd(e.mo), bcd(e.y)},
          req, {v8, v9, va, vb, vc, vd, ve, vf},
          {8'h40 | bcd(e.c), bcd(e.s), bcd(e.m), bcd(e.h), bcd(e.dw), bcd(e.d), bcd(e.mo), bcd(e.y)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    logic [7:0] v8, v9, va, vb, vc, vd, ve, vf, v;
    tm_t t;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(4'h8, v8); rd_reg(4'h9, v9); rd_reg(4'hA, va); rd_reg(4'hB, vb);
    rd_reg(4'hC, vc); rd_reg(4'hD, vd); rd_reg(4'hE, ve); rd_reg(4'hF, vf);
    check({v8, v9, va, vb, vc, vd, ve, vf} == 64'h2000_0000_0101_0100, "R1 reset",
          {v8, v9, va, vb, vc, vd, ve, vf}, 64'h2000_0000_0101_0100);

    // R2 R5 year and century rollover
    t = mk(59, 59, 23, 7, 31, 12, 99, 19); load_time(t); sample_after(t, 1, "R5 year end");
    t = mk(59, 59, 23, 3, 31, 12, 99, 39); load_time(t); sample_after(t, 1, "R5 century wrap");
    t = mk(58, 59, 22, 4, 15, 6, 10, 20);  load_time(t); sample_after(t, 2, "R2 hour carry");
    t = mk(59, 59, 23, 6, 14, 3, 11, 20);  load_time(t); sample_after(t, 1, "R2 day carry");
    // R4 leap year
    t = mk(59, 59, 23, 1, 28, 2, 24, 20);  load_time(t); sample_after(t, 1, "R4 feb 28 leap");
    t = mk(59, 59, 23, 2, 29, 2, 24, 20);  load_time(t); sample_after(t, 1, "R4 feb 29 end");
    t = mk(59, 59, 23, 2, 28, 2, 0, 21);   load_time(t); sample_after(t, 1, "R4 year 00");
    // R3 month lengths
    t = mk(59, 59, 23, 5, 28, 2, 23, 20);  load_time(t); sample_after(t, 1, "R3 feb non-leap");
    t = mk(59, 59, 23, 5, 30, 4, 23, 20);  load_time(t); sample_after(t, 1, "R3 april");
    t = mk(59, 59, 23, 5, 30, 1, 23, 20);  load_time(t); sample_after(t, 1, "R3 january 30");
    t = mk(59, 59, 23, 5, 30, 11, 23, 20); load_time(t); sample_after(t, 1, "R3 november");

    // R7 read hold
    t = mk(10, 20, 5, 2, 3, 5, 30, 20); load_time(t);
    repeat (TDIV + 5) @(negedge clk);
    wr_reg(4'h8, 8'h40);
    repeat (3 * TDIV) @(negedge clk);
    rd_reg(4'h9, v);
    check(v == bcd(11), "R7 frozen", v, bcd(11));
    wr_reg(4'h8, 8'h00);
    repeat (3) @(negedge clk);
    rd_reg(4'h9, v);
    check(v == bcd(14), "R7 resumes", v, bcd(14));

    // R8 write hold freeze, then load
    t = mk(40, 1, 2, 3, 4, 5, 6, 20); load_time(t);
    wr_reg(4'h8, 8'h80 | bcd(20));
    repeat (3 * TDIV) @(negedge clk);
    rd_reg(4'h9, v);
    check(v == bcd(40), "R8 frozen while hold", v, bcd(40));
    wr_reg(4'h9, bcd(30));
    rd_reg(4'h9, v);
    check(v == bcd(30), "R8 accepts write", v, bcd(30));
    wr_reg(4'h8, bcd(21));
    t = mk(30, 1, 2, 3, 4, 5, 6, 21);
    sample_after(t, 1, "R8 load then count");

    // R9 writes ignored without write hold
    t = mk(0, 15, 9, 1, 9, 9, 9, 20); load_time(t);
    repeat (4) @(negedge clk);
    wr_reg(4'hA, 8'h44);
    wr_reg(4'hF, 8'h77);
    rd_reg(4'hA, va); rd_reg(4'hF, vf);
    check({va, vf} == {bcd(15), bcd(9)}, "R9 ignored", {va, vf}, {bcd(15), bcd(9)});

    // R10 oscillator stop
    t = mk(10, 0, 0, 1, 1, 1, 1, 20); load_time(t);
    wr_reg(4'h9, 8'h80);
    repeat (3 * TDIV) @(negedge clk);
    rd_reg(4'h9, v);
    check(v == (8'h80 | bcd(10)), "R10 stopped", v, 8'h80 | bcd(10));
    wr_reg(4'h9, 8'h00);
    repeat (20) @(negedge clk);
    rd_reg(4'h9, v);
    check(v == bcd(11), "R10 resumed", v, bcd(11));

    // R11 frequency-test bit
    wr_reg(4'hC, 8'h47);
    rd_reg(4'hC, vc);
    check(vc == 8'h41, "R11 ft set", vc, 8'h41);
    wr_reg(4'hC, 8'h00);
    rd_reg(4'hC, vc);
    check(vc == 8'h01, "R11 ft clear", vc, 8'h01);

    // R6 low addresses
    wr_reg(4'h3, 8'hFF);
    rd_reg(4'h3, v);
    check(v == 8'h00, "R6 low addr 3", v, 8'h00);
    rd_reg(4'h0, v);
    check(v == 8'h00, "R6 low addr 0", v, 8'h00);

    // R12 R2 R3 R4 R5 random loads, half of them on a day boundary
    for (int i = 0; i < 24; i++) begin
      int k;
      t.mo = 1 + $urandom % 12;
      t.y  = $urandom % 100;
      t.c  = $urandom % 40;
      t.dw = 1 + $urandom % 7;
      if (i % 2 == 1) begin
        t.d = mdays(t.mo, t.y); t.h = 23; t.m = 59; t.s = 58 + $urandom % 2;
      end else begin
        t.d = 1 + $urandom % mdays(t.mo, t.y);
        t.h = $urandom % 24; t.m = $urandom % 60; t.s = $urandom % 60;
      end
      k = 1 + $urandom % 3;
      load_time(t);
      sample_after(t, k, "R12 random");
    end

    finish_run();
  end
endmodule